// File: doc/BRIEF.md
# Transport-Triggered Move Processor

This block is a minimal processor with a single instruction type. Each instruction moves one value from a numbered source port to a numbered destination port. Arithmetic, memory access, output, halting and branching all happen as side effects of those moves.

To add two numbers, a program writes an operation code to the ALU operation port, writes the first operand to the A port, and then writes the second operand to the B port. The write to B starts the operation. The result and the carry flag can be read by the very next move.

Jumps are writes to the instruction pointer port. A conditional skip uses an ALU operation that adds one word to its operand when the carry flag is set and adds zero otherwise. Moving that result into the instruction pointer steps over exactly one following word, or it does not.

The instruction memory is internal. It is filled through a load port while the core is idle. The core starts when `run` rises and stops on a move to the halt port, after which `done` stays high. Data memory and general registers are internal, and a program reports values by moving them to an output port.

Top module: `move_core`

## Requirements
- R1: After a synchronous reset, `done`, `out_valid` and `out_data` are zero, and execution begins with the instruction at address 0.
- R2: An instruction is 16 bits: source code in bits 15:8 and destination code in bits 7:0. Codes 0x00..0x03 name general registers R0..R3, both as sources and as destinations. A register-to-register move copies the value and leaves the other registers unchanged.
- R3: Source code 0x40 reads the 16-bit word that follows the instruction as an immediate. Execution then continues two words after the instruction.
- R4: The ALU has three write ports: operation select (destination 0x12, low 3 bits used), operand A (destination 0x10) and operand B (destination 0x11). Writing B computes the result with the last selected operation and the current A. The result is readable at source 0x10 by the next move. Operation codes: 0 add, 1 subtract A-B, 2 and, 3 or, 4 xor, 5 shift A left by one, 6 shift A right by one, 7 conditional skip.
- R5: Source 0x11 reads the carry flag as 0 or 1. Add sets it to the carry out. Subtract sets it when A >= B, unsigned. Shift left sets it to the old bit 15 of A, and shift right sets it to the old bit 0 of A. And, or and xor leave it unchanged. It is 0 after reset.
- R6: Operation 7 produces B plus the carry flag (one word when the carry is set, zero otherwise) and leaves the carry unchanged. Moving that result into the instruction pointer skips the next single-word instruction only when the carry is set.
- R7: Destination 0x21 sets the data RAM address (low 5 bits). Destination 0x20 writes the value to the RAM word at that address. Source 0x20 reads the RAM word at the address, and source 0x21 reads the address back.
- R8: Destination 0x30 writes the instruction pointer, so the next instruction is fetched from that value. Source 0x30 returns the address of the word that follows the current instruction.
- R9: A move to destination 0x50 drives the value on `out_data` and holds `out_valid` high for exactly one cycle.
- R10: A move to destination 0x7F raises `done`, which then stays high. No further instruction executes and no further output appears.
- R11: Writes to unmapped destination codes change no register, memory or output. Unmapped source codes read as zero.
- R12: While the core is idle before `run`, `ld_we` writes `ld_data` into instruction memory at `ld_addr`. Nothing executes until `run` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Instruction memory load strobe (idle only) |
| ld_addr | input | 8 | Instruction memory load address |
| ld_data | input | 16 | Instruction word to load |
| run | input | 1 | Start execution from the idle state |
| out_valid | output | 1 | One-cycle strobe for a move to the output port |
| out_data | output | 16 | Value last moved to the output port |
| done | output | 1 | Core has executed a halt move |

## Verification
The bench runs every ALU operation against a grid of edge operands (0, 1, 0x7FFF, 0x8000, 0xFFFF, 0x00F0), each with the carry preset to 0 and to 1. A design that updated the carry on logic operations, inverted the borrow sense, or took the shifted-out bit from the wrong end would report the wrong flag.

The conditional skip is run with both carry values. A wrong skip width or a wrong flag polarity shows up as a missing or extra output.

Every register source/destination pair is copied and all four registers are dumped, which catches a decode that writes the wrong register. All 32 RAM words are written and then read back in reverse order, which exposes address aliasing and a stale read before the read data settles.

The instruction pointer value seen after an immediate and after a jump, the unmapped codes, the silence after halt, and idleness until `run` are checked as well. Those checks catch an off-by-one pointer, a write leaking through a decode hole, and a core that keeps fetching.

// File: rtl/move_core_pkg.sv
package move_core_pkg;

  // Port codes (source side)
  localparam logic [7:0] SRC_ALU_RES  = 8'h10;
  localparam logic [7:0] SRC_CARRY    = 8'h11;
  localparam logic [7:0] SRC_RAM_DATA = 8'h20;
  localparam logic [7:0] SRC_RAM_ADDR = 8'h21;
  localparam logic [7:0] SRC_IP       = 8'h30;
  localparam logic [7:0] SRC_IMM      = 8'h40;

  // Port codes (destination side)
  localparam logic [7:0] DST_ALU_A    = 8'h10;
  localparam logic [7:0] DST_ALU_B    = 8'h11;
  localparam logic [7:0] DST_ALU_OP   = 8'h12;
  localparam logic [7:0] DST_RAM_DATA = 8'h20;
  localparam logic [7:0] DST_RAM_ADDR = 8'h21;
  localparam logic [7:0] DST_IP       = 8'h30;
  localparam logic [7:0] DST_OUT      = 8'h50;
  localparam logic [7:0] DST_HALT     = 8'h7F;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_XOR   = 3'd4,
    OP_SHL   = 3'd5,
    OP_SHR   = 3'd6,
    OP_CSKIP = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_IMM,
    ST_HALT
  } core_state_e;

endpackage

// File: rtl/move_imem.sv
module move_imem #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  // Simple dual-port: one write port, one registered read port.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/move_dmem.sv
module move_dmem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Single port, read-first, registered read.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/move_regfile.sv
module move_regfile #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4,
  localparam int RAW     = $clog2(NUM_REGS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  logic [RAW-1:0]                   waddr,
  input  logic [DATA_W-1:0]                wdata,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                              regs[g] <= '0;
      else if (we && waddr == RAW'(g))      regs[g] <= wdata;
    end
  end

endmodule

// File: rtl/move_alu.sv
module move_alu
  import move_core_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_we,
  input  logic [DATA_W-1:0] a_wd,
  input  logic              op_we,
  input  logic [2:0]        op_wd,
  input  logic              trig,
  input  logic [DATA_W-1:0] b_wd,
  output logic [DATA_W-1:0] res_q,
  output logic              carry_q
);

  logic [DATA_W-1:0] a_q;
  alu_op_e           op_q;
  logic [DATA_W-1:0] res_d;
  logic              carry_d;
  logic [DATA_W:0]   sum_w;

  always_comb begin
    sum_w   = {1'b0, a_q} + {1'b0, b_wd};
    res_d   = res_q;
    carry_d = carry_q;
    unique case (op_q)
      OP_ADD: begin
        res_d   = sum_w[DATA_W-1:0];
        carry_d = sum_w[DATA_W];
      end
      OP_SUB: begin
        res_d   = a_q - b_wd;
        carry_d = (a_q >= b_wd);
      end
      OP_AND: res_d = a_q & b_wd;
      OP_OR:  res_d = a_q | b_wd;
      OP_XOR: res_d = a_q ^ b_wd;
      OP_SHL: begin
        res_d   = {a_q[DATA_W-2:0], 1'b0};
        carry_d = a_q[DATA_W-1];
      end
      OP_SHR: begin
        res_d   = {1'b0, a_q[DATA_W-1:1]};
        carry_d = a_q[0];
      end
      OP_CSKIP: res_d = b_wd + {{(DATA_W-1){1'b0}}, carry_q};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q     <= '0;
      op_q    <= OP_ADD;
      res_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      if (a_we)  a_q  <= a_wd;
      if (op_we) op_q <= alu_op_e'(op_wd);
      if (trig) begin
        res_q   <= res_d;
        carry_q <= carry_d;
      end
    end
  end

  // R4: subtract result added back to B reproduces A
  p_sub_inverse_r4: assert property (@(posedge clk) disable iff (rst)
    (trig && op_q == OP_SUB) |=> ((res_q + $past(b_wd)) == $past(a_q)));

  // R5: add carry out is set exactly when the sum wrapped below A
  p_add_carry_r5: assert property (@(posedge clk) disable iff (rst)
    (trig && op_q == OP_ADD) |=> (carry_q == (res_q < $past(a_q))));

  // R5: logic operations keep the flag
  p_logic_keeps_carry_r5: assert property (@(posedge clk) disable iff (rst)
    (trig && (op_q == OP_AND || op_q == OP_OR || op_q == OP_XOR)) |=> $stable(carry_q));

  // R6: conditional step is B or B+1 and keeps the flag
  p_cskip_step_r6: assert property (@(posedge clk) disable iff (rst)
    (trig && op_q == OP_CSKIP) |=>
      ((res_q == $past(b_wd) || res_q == $past(b_wd) + 1'b1) && $stable(carry_q)));

endmodule

// File: rtl/move_core.sv
module move_core
  import move_core_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int IMEM_DEPTH = 256,
  parameter int DMEM_DEPTH = 32,
  parameter int NUM_REGS   = 4,
  localparam int INSN_W    = 16,
  localparam int IAW       = $clog2(IMEM_DEPTH),
  localparam int DAW       = $clog2(DMEM_DEPTH),
  localparam int RAW       = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic [IAW-1:0]    ld_addr,
  input  logic [INSN_W-1:0] ld_data,
  input  logic              run,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              done
);

  core_state_e                      state_q;
  logic [IAW-1:0]                   ip_q;
  logic [INSN_W-1:0]                ir_q;
  logic [DAW-1:0]                   ram_addr_q;
  logic                             done_q;
  logic                             out_valid_q;
  logic [DATA_W-1:0]                out_data_q;

  logic [INSN_W-1:0]                imem_rd;
  logic [DATA_W-1:0]                dmem_rd;
  logic [NUM_REGS-1:0][DATA_W-1:0]  rf_q;
  logic [DATA_W-1:0]                alu_res;
  logic                             alu_carry;

  logic [INSN_W-1:0]                cur_insn;
  logic [7:0]                       src_code;
  logic [7:0]                       dst_code;
  logic                             exec_en;
  logic                             needs_imm;
  logic [DATA_W-1:0]                src_val;

  logic w_reg, w_alu_a, w_alu_b, w_alu_op, w_ram_data, w_ram_addr, w_ip, w_out, w_halt;

  // ---------------- instruction side ----------------
  move_imem #(.WORD_W(INSN_W), .DEPTH(IMEM_DEPTH)) u_imem (
    .clk   (clk),
    .we    (ld_we && state_q == ST_IDLE),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (ip_q),
    .rdata (imem_rd)
  );

  assign cur_insn  = (state_q == ST_IMM) ? ir_q : imem_rd;
  assign src_code  = cur_insn[15:8];
  assign dst_code  = cur_insn[7:0];
  assign needs_imm = (state_q == ST_DECODE) && (imem_rd[15:8] == SRC_IMM);
  assign exec_en   = (state_q == ST_IMM) || (state_q == ST_DECODE && !needs_imm);

  // ---------------- source selection ----------------
  always_comb begin
    src_val = '0;
    if (int'(src_code) < NUM_REGS) begin
      src_val = rf_q[src_code[RAW-1:0]];
    end else begin
      unique case (src_code)
        SRC_ALU_RES:  src_val = alu_res;
        SRC_CARRY:    src_val = {{(DATA_W-1){1'b0}}, alu_carry};
        SRC_RAM_DATA: src_val = dmem_rd;
        SRC_RAM_ADDR: src_val = DATA_W'(ram_addr_q);
        SRC_IP:       src_val = DATA_W'(ip_q);
        SRC_IMM:      src_val = imem_rd;
        default:      src_val = '0;
      endcase
    end
  end

  // ---------------- destination decode ----------------
  always_comb begin
    w_reg      = exec_en && (int'(dst_code) < NUM_REGS);
    w_alu_a    = exec_en && dst_code == DST_ALU_A;
    w_alu_b    = exec_en && dst_code == DST_ALU_B;
    w_alu_op   = exec_en && dst_code == DST_ALU_OP;
    w_ram_data = exec_en && dst_code == DST_RAM_DATA;
    w_ram_addr = exec_en && dst_code == DST_RAM_ADDR;
    w_ip       = exec_en && dst_code == DST_IP;
    w_out      = exec_en && dst_code == DST_OUT;
    w_halt     = exec_en && dst_code == DST_HALT;
  end

  // ---------------- functional units ----------------
  move_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (w_reg),
    .waddr (dst_code[RAW-1:0]),
    .wdata (src_val),
    .regs  (rf_q)
  );

  move_alu #(.DATA_W(DATA_W)) u_alu (
    .clk     (clk),
    .rst     (rst),
    .a_we    (w_alu_a),
    .a_wd    (src_val),
    .op_we   (w_alu_op),
    .op_wd   (src_val[2:0]),
    .trig    (w_alu_b),
    .b_wd    (src_val),
    .res_q   (alu_res),
    .carry_q (alu_carry)
  );

  move_dmem #(.DATA_W(DATA_W), .DEPTH(DMEM_DEPTH)) u_dmem (
    .clk   (clk),
    .we    (w_ram_data),
    .addr  (ram_addr_q),
    .wdata (src_val),
    .rdata (dmem_rd)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      ip_q        <= '0;
      ir_q        <= '0;
      ram_addr_q  <= '0;
      done_q      <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= w_out;
      if (w_out)      out_data_q <= src_val;
      if (w_ram_addr) ram_addr_q <= src_val[DAW-1:0];

      unique case (state_q)
        ST_IDLE: if (run) state_q <= ST_FETCH;
        ST_FETCH: begin
          ip_q    <= ip_q + 1'b1;
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          if (needs_imm) begin
            ir_q    <= imem_rd;
            ip_q    <= ip_q + 1'b1;
            state_q <= ST_IMM;
          end else begin
            state_q <= w_halt ? ST_HALT : ST_FETCH;
          end
        end
        ST_IMM:  state_q <= w_halt ? ST_HALT : ST_FETCH;
        ST_HALT: ;
        default: state_q <= ST_IDLE;
      endcase

      if (w_ip)   ip_q   <= src_val[IAW-1:0];
      if (w_halt) done_q <= 1'b1;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign done      = done_q;

  // R9: output strobe lasts one cycle
  p_out_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid_q |=> !out_valid_q);

  // R10: done stays raised and the pointer stops moving
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    done_q |=> (done_q && $stable(ip_q)));

  // R10: nothing reaches the output once halted
  p_quiet_after_halt_r10: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !out_valid_q);

  // R12: idle core holds its pointer until run
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !run) |=> (state_q == ST_IDLE && $stable(ip_q)));

  // R3: the immediate word sits one past the instruction
  p_imm_step_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IMM) |-> (ip_q == IAW'($past(ip_q) + 1'b1)));

endmodule

// File: tb/move_core_tb.sv
module move_core_tb;

  localparam int DW  = 16;
  localparam int IAW = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ld_we = 1'b0;
  logic [IAW-1:0] ld_addr = '0;
  logic [15:0]    ld_data = '0;
  logic           run = 1'b0;
  logic           out_valid;
  logic [DW-1:0]  out_data;
  logic           done;

  always #5 clk = ~clk;

  move_core u_dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .run(run), .out_valid(out_valid), .out_data(out_data), .done(done)
  );

  int nchk = 0;
  int nfail = 0;

  logic [15:0] prog [0:255];
  int          plen;
  logic [15:0] cap [0:255];
  int          ncap = 0;

  always @(negedge clk) if (!rst && out_valid && ncap < 256) begin
    cap[ncap] = out_data;
    ncap++;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mv(input logic [7:0] s, input logic [7:0] d);
    return {s, d};
  endfunction

  task automatic emit(input logic [15:0] w);
    prog[plen] = w;
    plen++;
  endtask

  task automatic mvi(input logic [15:0] v, input logic [7:0] d);
    emit(mv(8'h40, d));
    emit(v);
  endtask

  task automatic load_prog();
    @(negedge clk);
    rst = 1'b1; run = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    ncap = 0;
    for (int i = 0; i < plen; i++) begin
      ld_we = 1'b1; ld_addr = IAW'(i); ld_data = prog[i];
      @(negedge clk);
    end
    ld_we = 1'b0;
  endtask

  task automatic go(input string req);
    bit fin = 0;
    run = 1'b1;
    for (int i = 0; i < 3000 && !fin; i++) begin
      @(negedge clk);
      if (done) fin = 1;
    end
    run = 1'b0;
    if (!fin) begin
      nchk++; nfail++;
      $display("FAIL %s: got no halt expected done", req);
    end
  endtask

  task automatic set_carry(input bit c);
    mvi(16'd0, 8'h12);
    mvi(16'hFFFF, 8'h10);
    mvi({15'd0, c}, 8'h11);
  endtask

  function automatic void model(input int op, input logic [15:0] a, input logic [15:0] b,
                                input logic cin, output logic [15:0] r, output logic c);
    logic [16:0] w;
    c = cin;
    case (op)
      0: begin w = 17'(a) + 17'(b); r = w[15:0]; c = w[16]; end
      1: begin r = a - b; c = (a >= b); end
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: begin r = a << 1; c = a[15]; end
      6: begin r = a >> 1; c = a[0]; end
      default: r = b + 16'(cin);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] vals [0:5];
    logic [15:0] er;
    logic        ec;
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF;
    vals[3] = 16'h8000; vals[4] = 16'hFFFF; vals[5] = 16'h00F0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 done", {15'd0, done}, 16'd0);
    chk("R1 out_valid", {15'd0, out_valid}, 16'd0);
    chk("R1 out_data", out_data, 16'd0);

    // R12: loaded program does not run without run
    plen = 0;
    mvi(16'h7777, 8'h50);
    emit(mv(8'h00, 8'h7F));
    load_prog();
    repeat (20) @(negedge clk);
    chk("R12 idle done", {15'd0, done}, 16'd0);
    chk("R12 idle outputs", 16'(ncap), 16'd0);
    go("R12");
    chk("R12 count", 16'(ncap), 16'd1);
    chk("R12 value", cap[0], 16'h7777);

    // R2 R3 R8: immediate, copy, IP read after immediates
    plen = 0;
    mvi(16'h1234, 8'h00);
    emit(mv(8'h00, 8'h03));
    emit(mv(8'h03, 8'h50));
    mvi(16'h5A5A, 8'h50);
    emit(mv(8'h30, 8'h50));   // at address 6
    emit(mv(8'h03, 8'h7F));
    load_prog(); go("R2");
    chk("R9 count", 16'(ncap), 16'd3);
    chk("R2 copy", cap[0], 16'h1234);
    chk("R3 immediate", cap[1], 16'h5A5A);
    chk("R8 ip read", cap[2], 16'd7);

    // R2: every source/destination register pair
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 4; d++) begin
        plen = 0;
        for (int k = 0; k < 4; k++) mvi(16'hC000 + 16'(k), 8'(k));
        emit(mv(8'(s), 8'(d)));
        for (int k = 0; k < 4; k++) emit(mv(8'(k), 8'h50));
        emit(mv(8'h40, 8'h7F)); emit(16'd0);
        load_prog(); go("R2 pair");
        for (int k = 0; k < 4; k++)
          chk("R2 pair reg", cap[k], (k == d) ? 16'hC000 + 16'(s) : 16'hC000 + 16'(k));
      end
    end

    // R4 R5 R6: ALU sweep
    for (int op = 0; op < 8; op++) begin
      for (int cin = 0; cin < 2; cin++) begin
        for (int ia = 0; ia < 6; ia++) begin
          for (int ib = 0; ib < 6; ib++) begin
            plen = 0;
            set_carry(cin[0]);
            mvi(16'(op), 8'h12);
            mvi(vals[ia], 8'h10);
            mvi(vals[ib], 8'h11);
            emit(mv(8'h10, 8'h50));
            emit(mv(8'h11, 8'h50));
            emit(mv(8'h00, 8'h7F));
            load_prog(); go("R4 sweep");
            model(op, vals[ia], vals[ib], cin[0], er, ec);
            if (op == 7) begin
              chk("R6 cskip result", cap[0], er);
              chk("R6 cskip carry", cap[1], {15'd0, ec});
            end else begin
              chk("R4 result", cap[0], er);
              chk("R5 carry", cap[1], {15'd0, ec});
            end
          end
        end
      end
    end

    // R6: skip flow through the instruction pointer
    for (int cin = 0; cin < 2; cin++) begin
      plen = 0;
      mvi(16'hAAAA, 8'h00);
      mvi(16'hBBBB, 8'h01);
      set_carry(cin[0]);
      mvi(16'd7, 8'h12);
      mvi(16'd15, 8'h11);        // words 12..13
      emit(mv(8'h10, 8'h30));    // word 14
      emit(mv(8'h00, 8'h50));    // word 15
      emit(mv(8'h01, 8'h50));    // word 16
      emit(mv(8'h00, 8'h7F));
      load_prog(); go("R6 skip");
      if (cin == 1) begin
        chk("R6 skip taken count", 16'(ncap), 16'd1);
        chk("R6 skip taken value", cap[0], 16'hBBBB);
      end else begin
        chk("R6 fallthrough count", 16'(ncap), 16'd2);
        chk("R6 fallthrough first", cap[0], 16'hAAAA);
        chk("R6 fallthrough second", cap[1], 16'hBBBB);
      end
    end

    // R8: absolute jump
    plen = 0;
    mvi(16'd6, 8'h30);
    mvi(16'hDEAD, 8'h50);
    emit(mv(8'h00, 8'h7F));
    emit(mv(8'h00, 8'h7F));
    emit(mv(8'h30, 8'h50));     // word 6
    mvi(16'hBEEF, 8'h50);       // words 7..8
    emit(mv(8'h30, 8'h50));     // word 9
    emit(mv(8'h00, 8'h7F));
    load_prog(); go("R8 jump");
    chk("R8 jump count", 16'(ncap), 16'd3);
    chk("R8 ip after jump", cap[0], 16'd7);
    chk("R8 landing", cap[1], 16'hBEEF);
    chk("R8 ip after imm", cap[2], 16'd10);

    // R7: all RAM words written then read back in reverse
    plen = 0;
    for (int a = 0; a < 32; a++) begin
      mvi(16'(a), 8'h21);
      mvi(16'h5000 ^ 16'(a * 37 + 5), 8'h20);
    end
    for (int a = 31; a >= 0; a--) begin
      mvi(16'(a), 8'h21);
      emit(mv(8'h20, 8'h50));
    end
    emit(mv(8'h21, 8'h50));
    emit(mv(8'h02, 8'h7F));
    load_prog(); go("R7 ram");
    chk("R7 count", 16'(ncap), 16'd33);
    for (int a = 31; a >= 0; a--)
      chk("R7 ram word", cap[31 - a], 16'h5000 ^ 16'(a * 37 + 5));
    chk("R7 addr read", cap[32], 16'd0);

    // R11: unmapped destinations and sources
    plen = 0;
    mvi(16'h1111, 8'h00);
    mvi(16'h2222, 8'h01);
    mvi(16'h3333, 8'h66);
    mvi(16'h4444, 8'h04);
    for (int k = 0; k < 4; k++) emit(mv(8'(k), 8'h50));
    emit(mv(8'h77, 8'h50));
    emit(mv(8'h00, 8'h7F));
    load_prog(); go("R11");
    chk("R11 count", 16'(ncap), 16'd5);
    chk("R11 r0", cap[0], 16'h1111);
    chk("R11 r1", cap[1], 16'h2222);
    chk("R11 r2", cap[2], 16'h0000);
    chk("R11 r3", cap[3], 16'h0000);
    chk("R11 unmapped src", cap[4], 16'h0000);

    // R10: halt stops everything
    plen = 0;
    mvi(16'hCAFE, 8'h50);
    emit(mv(8'h00, 8'h7F));
    mvi(16'h0BAD, 8'h50);
    load_prog(); go("R10");
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R10 done held", {15'd0, done}, 16'd1);
      chk("R10 no strobe", {15'd0, out_valid}, 16'd0);
    end
    chk("R10 count", 16'(ncap), 16'd1);
    chk("R10 value", out_data, 16'hCAFE);

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule